// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns parallel stereo PCM sample pairs into a three-wire serial audio stream: a bit clock, a word-select line that marks the left and right channel, and a serial data line. It runs on the audio master clock and divides it internally. A frame is always 64 bit clocks: a 32-bit slot for the left channel followed by a 32-bit slot for the right channel. The bit clock is therefore the master clock divided by one sixty-fourth of the selected master-clock-to-sample-rate ratio.

Run-time configuration inputs set the sample width and the ratio. They also set the layout of each slot: the sample may be placed at the start or the end of the slot, its bits may be sent most or least significant first, and the slot data may be held back by one bit clock after each word-select edge, as standard I2S framing does. Configuration and sample data are captured together at the start of every frame, so a frame never mixes two settings.

Sample pairs enter through a valid/ready handshake into a single holding register. If the holding register is empty when a frame starts, the previous pair is sent again and a one-cycle underrun pulse is raised.

Top module: `serial_pcm_tx`

## Requirements
- R1: While reset is asserted, the bit clock, word-select, serial data and underrun outputs are low, and the block is ready for input.
- R2: The bit clock period is 2, 3, 4, 6 or 8 master clocks for a ratio code of 0, 1, 2, 3 or 4 (ratios 128, 192, 256, 384, 512). Codes above 4 act as code 4. For a period of 3, the bit clock is low for 2 cycles and high for 1.
- R3: Word-select is low for the 32 bit clocks of the left slot and high for the 32 bit clocks of the right slot. It changes only at the start of a slot.
- R4: With the bit-order input at 0, sample bits go out from the most significant valid bit down. With it at 1, they go out from bit 0 up.
- R5: With the justify input at 0, the sample occupies the first W bits of its slot. With it at 1, the sample occupies the last W bits of its slot. All other slot bits are 0.
- R6: The width code sets W to 16, 18, 20, 24 or 32 for codes 0, 1, 2, 3 or 4; codes above 4 act as code 4. Input bits at W and above are ignored.
- R7: With the delay input at 1, every slot bit is sent one bit clock later than with it at 0. Bit 0 of each slot then carries the last slot bit of the preceding channel.
- R8: A pair is accepted when valid and ready are both high. Ready is low while the holding register is full, and input offered while ready is low is ignored.
- R9: A held pair is moved into the transmitter at the start of a frame. If no pair is held at that point, the previous pair is sent again and underrun is high for exactly one master-clock cycle.
- R10: Configuration inputs are sampled only at the start of a frame. A change in the middle of a frame does not affect that frame.
- R11: Word-select and serial data change only on a falling edge of the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ratio | input | 3 | Master-clock ratio code (0:128, 1:192, 2:256, 3:384, 4:512) |
| cfg_width | input | 3 | Sample width code (0:16, 1:18, 2:20, 3:24, 4:32) |
| cfg_delay | input | 1 | 1 = one-bit delay after each word-select edge |
| cfg_rjust | input | 1 | 1 = sample at the end of its slot |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register is empty |
| in_left | input | 32 | Left sample, right-aligned in the word |
| in_right | input | 32 | Right sample, right-aligned in the word |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word-select: 0 left, 1 right |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse when a pair is repeated |

## Verification
The block has no elaboration parameters, so the bench builds the single default form. It reaches every variant through the run-time inputs: all five ratio codes and all five width codes, each paired with a different combination of delay, justification and bit order. Each case is checked on a whole deserialized frame, including the spill bit at slot position 0 in delay mode. A directed case changes the configuration part-way through a frame. It expects the old layout to finish that frame, and the following underrun frame to repeat the same pair under the new layout.

// File: rtl/serial_pcm_tx.sv
module serial_pcm_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_ratio,
  input  logic [2:0]  cfg_width,
  input  logic        cfg_delay,
  input  logic        cfg_rjust,
  input  logic        cfg_lsb_first,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_left,
  input  logic [31:0] in_right,
  output logic        bclk_o,
  output logic        ws_o,
  output logic        sd_o,
  output logic        underrun_o
);

  typedef struct packed {
    logic [2:0] ratio;
    logic [2:0] width;
    logic       dly;
    logic       rj;
    logic       lsb;
  } cfg_t;

  function automatic logic [5:0] width_of(input logic [2:0] c);
    case (c)
      3'd0:    return 6'd16;
      3'd1:    return 6'd18;
      3'd2:    return 6'd20;
      3'd3:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [3:0] div_of(input logic [2:0] c);
    case (c)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic slot_bit(input logic [31:0] s, input logic [4:0] k,
                                    input cfg_t c);
    logic [5:0] w, off, j, idx;
    w   = width_of(c.width);
    off = c.rj ? 6'd32 - w : 6'd0;
    if ({1'b0, k} < off || {1'b0, k} >= off + w) return 1'b0;
    j   = {1'b0, k} - off;
    idx = c.lsb ? j : w - 6'd1 - j;
    return s[idx[4:0]];
  endfunction

  cfg_t        cur_cfg, nxt_cfg;
  logic [31:0] cur_l, cur_r, hold_l, hold_r, nl, nr, smp;
  logic        hold_full, run, spill, tick, fstart, sd_nxt;
  logic [2:0]  div_cnt, div_nxt;
  logic [5:0]  bit_cnt, pos;
  logic [3:0]  div_cur, div_new;

  assign in_ready = !hold_full;
  assign div_cur  = div_of(cur_cfg.ratio);
  assign tick     = !run || ({1'b0, div_cnt} == div_cur - 4'd1);
  assign pos      = bit_cnt + 6'd1;
  assign fstart   = tick && (pos == 6'd0);
  assign nxt_cfg  = fstart ? cfg_t'{cfg_ratio, cfg_width, cfg_delay, cfg_rjust, cfg_lsb_first}
                           : cur_cfg;
  assign nl       = (fstart && hold_full) ? hold_l : cur_l;
  assign nr       = (fstart && hold_full) ? hold_r : cur_r;
  assign smp      = pos[5] ? nr : nl;
  assign div_nxt  = tick ? 3'd0 : div_cnt + 3'd1;
  assign div_new  = div_of(nxt_cfg.ratio);

  always_comb begin
    if (!nxt_cfg.dly)         sd_nxt = slot_bit(smp, pos[4:0], nxt_cfg);
    else if (pos[4:0] == 5'd0) sd_nxt = spill;
    else                      sd_nxt = slot_bit(smp, pos[4:0] - 5'd1, nxt_cfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cfg    <= '0;
      cur_l      <= '0;
      cur_r      <= '0;
      hold_l     <= '0;
      hold_r     <= '0;
      hold_full  <= 1'b0;
      run        <= 1'b0;
      div_cnt    <= '0;
      bit_cnt    <= 6'd63;
      spill      <= 1'b0;
      bclk_o     <= 1'b0;
      ws_o       <= 1'b0;
      sd_o       <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      div_cnt    <= div_nxt;
      bclk_o     <= {1'b0, div_nxt} >= (div_new - (div_new >> 1));
      underrun_o <= fstart && !hold_full;
      if (tick) begin
        run     <= 1'b1;
        bit_cnt <= pos;
        cur_cfg <= nxt_cfg;
        cur_l   <= nl;
        cur_r   <= nr;
        ws_o    <= pos[5];
        sd_o    <= sd_nxt;
        if (pos[4:0] == 5'd31) spill <= slot_bit(smp, 5'd31, nxt_cfg);
      end
      if (fstart && hold_full) begin
        hold_full <= 1'b0;
      end else if (in_valid && !hold_full) begin
        hold_l    <= in_left;
        hold_r    <= in_right;
        hold_full <= 1'b1;
      end
    end
  end

  a_r3_ws_at_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> bit_cnt[4:0] == 5'd0);

  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r9_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o);

  a_r10_cfg_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_cfg) |-> bit_cnt == 6'd0 && div_cnt == 3'd0);

  a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ws_o) || !$stable(sd_o)) |-> $fell(bclk_o) || $past(!run));

endmodule

// File: tb/test_serial_pcm_tx.sv
`timescale 1ns/1ps
module test_serial_pcm_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_ratio = '0, cfg_width = '0;
  logic        cfg_delay = 1'b0, cfg_rjust = 1'b0, cfg_lsb_first = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_left = '0, in_right = '0;
  logic        in_ready, bclk_o, ws_o, sd_o, underrun_o;

  int checks = 0, errors = 0;

  serial_pcm_tx i_serial_pcm_tx (.*);

  always #5 clk = ~clk;

  // Deserializer: samples on the rising bit clock, frame starts when word-select falls.
  logic [63:0] cap_d, cap_ws, last_d, last_ws;
  logic        prev_ws = 1'b1;
  int          pos = 0, frames_done = 0;
  realtime     t_prev = 0, per = 0, last_per = 0;
  int          under_cnt = 0;

  always @(posedge bclk_o) begin
    if (prev_ws && !ws_o) pos = 0; else pos = pos + 1;
    prev_ws = ws_o;
    per     = $realtime - t_prev;
    t_prev  = $realtime;
    if (pos < 64) begin
      cap_d[pos]  = sd_o;
      cap_ws[pos] = ws_o;
    end
    if (pos == 63) begin
      last_d      = cap_d;
      last_ws     = cap_ws;
      last_per    = per;
      frames_done = frames_done + 1;
    end
  end

  always @(posedge clk) if (rst_n && underrun_o) under_cnt <= under_cnt + 1;

  // {ratio, width, delay, rjust, lsb, left, right}
  localparam logic [72:0] VEC [8] = '{
    {3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 32'hFFFF_A5C3, 32'h0000_1234},
    {3'd1, 3'd4, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h8000_0001},
    {3'd2, 3'd3, 1'b0, 1'b1, 1'b0, 32'hFFAB_CDEF, 32'h0012_3456},
    {3'd3, 3'd1, 1'b1, 1'b1, 1'b0, 32'h0002_ACE1, 32'hFFFD_0137},
    {3'd4, 3'd2, 1'b0, 1'b0, 1'b1, 32'h000F_0F0F, 32'h0003_1111},
    {3'd2, 3'd0, 1'b1, 1'b0, 1'b1, 32'h0000_8001, 32'h0000_7FFE},
    {3'd0, 3'd3, 1'b1, 1'b1, 1'b1, 32'h00C0_0003, 32'h0055_AA55},
    {3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 32'h0008_0001, 32'h000A_BCDE}
  };

  function automatic logic [31:0] mk_slot(logic [31:0] s, logic [2:0] wc, logic rj, logic lsb);
    logic [31:0] v;
    int w;
    v = '0;
    w = (wc == 0) ? 16 : (wc == 1) ? 18 : (wc == 2) ? 20 : (wc == 3) ? 24 : 32;
    for (int j = 0; j < w; j++) v[rj ? 32 - w + j : j] = lsb ? s[j] : s[w - 1 - j];
    return v;
  endfunction

  function automatic logic [63:0] mk_frame(logic [31:0] ls, logic [31:0] rs, logic dly, logic spill);
    if (!dly) return {rs, ls};
    return {rs[30:0], ls[31], ls[30:0], spill};
  endfunction

  function automatic int per_of(logic [2:0] rc);
    return (rc == 0) ? 2 : (rc == 1) ? 3 : (rc == 2) ? 4 : (rc == 3) ? 6 : 8;
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  logic prev_r31 = 1'b0;

  task automatic drive_cfg(input logic [72:0] v);
    cfg_ratio = v[72:70]; cfg_width = v[69:67]; cfg_delay = v[66];
    cfg_rjust = v[65]; cfg_lsb_first = v[64];
  endtask

  task automatic run_case(input logic [72:0] a, input bit sw, input logic [72:0] b);
    int c0, u0;
    logic [31:0] ls, rs, ls2, rs2;
    logic [63:0] ef;
    c0 = frames_done;
    wait (frames_done == c0 + 1);
    @(posedge bclk_o); @(posedge bclk_o);
    @(negedge clk);
    drive_cfg(a);
    in_left = a[63:32]; in_right = a[31:0]; in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R8 ready low when full", {63'd0, in_ready}, 64'd0);
    in_left = 32'h1357_9BDF; in_right = 32'h2468_ACE0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    u0 = under_cnt;
    wait (frames_done == c0 + 2);
    if (sw) begin
      @(posedge bclk_o); @(posedge bclk_o); @(posedge bclk_o);
      @(negedge clk);
      drive_cfg(b);
    end
    wait (frames_done == c0 + 3);
    ls = mk_slot(a[63:32], a[69:67], a[65], a[64]);
    rs = mk_slot(a[31:0],  a[69:67], a[65], a[64]);
    ef = mk_frame(ls, rs, a[66], prev_r31);
    check(last_d == ef, "R4 R5 R6 R7 R8 frame data", last_d, ef);
    check(last_ws == 64'hFFFF_FFFF_0000_0000, "R3 word-select pattern", last_ws, 64'hFFFF_FFFF_0000_0000);
    check(int'(last_per / 10.0) == per_of(a[72:70]), "R2 bit clock period",
          64'(int'(last_per / 10.0)), 64'(per_of(a[72:70])));
    check(under_cnt == u0, "R9 no underrun when data held", 64'(under_cnt - u0), 64'd0);
    wait (frames_done == c0 + 4);
    check(under_cnt == u0 + 1, "R9 one underrun pulse", 64'(under_cnt - u0), 64'd1);
    if (sw) begin
      ls2 = mk_slot(a[63:32], b[69:67], b[65], b[64]);
      rs2 = mk_slot(a[31:0],  b[69:67], b[65], b[64]);
      ef  = mk_frame(ls2, rs2, b[66], rs[31]);
      check(last_d == ef, "R10 R9 repeat under new config", last_d, ef);
      check(int'(last_per / 10.0) == per_of(b[72:70]), "R10 new period",
            64'(int'(last_per / 10.0)), 64'(per_of(b[72:70])));
      prev_r31 = rs2[31];
    end else begin
      ef = mk_frame(ls, rs, a[66], rs[31]);
      check(last_d == ef, "R9 repeated pair", last_d, ef);
      prev_r31 = rs[31];
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check({bclk_o, ws_o, sd_o, underrun_o} == 4'b0, "R1 outputs low in reset",
          {60'd0, bclk_o, ws_o, sd_o, underrun_o}, 64'd0);
    check(in_ready == 1'b1, "R1 ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) run_case(VEC[i], 1'b0, VEC[i]);
    run_case(VEC[2], 1'b1, {3'd4, 3'd0, 1'b1, 1'b0, 1'b1, 64'd0});
    run_case(VEC[1], 1'b1, {3'd1, 3'd3, 1'b0, 1'b1, 1'b0, 64'd0});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule